// File: doc/BRIEF.md
# Keyboard Pin Interrupt Controller

This block watches eight general-purpose input pins and raises a single interrupt request when an enabled pin shows the edge or level that software selected for it. Each pin passes through a two-stage synchroniser. Edges are then found by comparing the synchronised value with the sample from the cycle before.

Software configures the block through a small register port with three 8-bit registers: control/status, pin enable and polarity select. A mode bit chooses one of two detection schemes. In the first, pins trigger on edges only. In the second, pins trigger on edges and also while they sit at their active level.

A sticky pending flag records each event. Software can read the flag but cannot write it. Software clears the flag by writing one to an acknowledge bit, which always reads back as zero. An enable bit masks the request output.

Top module: `kbd_irq_ctrl`

## Requirements
- R1: After reset, all three registers read 0 and `irq_o` is 0.
- R2: In the control register (address 0), bit 3 is the pending flag, bit 2 is the acknowledge bit, bit 1 is the interrupt enable and bit 0 is the mode bit. Bits 7..4 and bit 2 always read 0.
- R3: A write to control bit 3 has no effect. Only a detected event sets the flag.
- R4: Writing 1 to control bit 2 clears the pending flag when no event is detected in that same cycle.
- R5: `irq_o` is 1 exactly when the pending flag is 1 and the enable bit is 1. Clearing the enable bit masks the request but leaves the flag unchanged.
- R6: With mode 0, only a transition sets the flag. A pin held at a constant value does not set the flag again after an acknowledge.
- R7: A polarity bit of 0 selects a falling edge or a low level. A polarity bit of 1 selects a rising edge or a high level.
- R8: A pin whose enable bit (address 1) is 0 never sets the flag.
- R9: With mode 1, an enabled pin at its active level keeps the flag set, so an acknowledge has no effect while that level holds.
- R10: If an event and an acknowledge write occur in the same cycle, the flag ends up set.
- R11: Address 1 reads the pin enable register and address 2 reads the polarity register. Address 3 reads 0, and `rdata_o` is 0 whenever `rd_en_i` is 0.
- R12: A pin change applied before clock edge k is first visible on `irq_o` after edge k+2, and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | 8 | Asynchronous pin inputs |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational, 0 when not reading) |
| irq_o | output | 1 | Interrupt request |

## Verification
The properties assume the register strobes are clean, single-cycle levels that are stable around the clock edge. They also assume a read and a write never target the same register in the same cycle. The bench keeps to these assumptions by driving every port on the falling clock edge and by never issuing a read and a write together.

The bench holds each pin value for at least one full cycle, so that every transition reaches the synchroniser as a well-defined sample. Same-cycle collisions between an event and an acknowledge are placed deliberately by counting clock edges from the pin change.

// File: rtl/kbd_irq_pkg.sv
// Shared constants and types for the keyboard pin interrupt controller.
// Assumes an 8-bit register port with a 2-bit address.
package kbd_irq_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL     = 2'd0,
        ADDR_ENABLE   = 2'd1,
        ADDR_POLARITY = 2'd2,
        ADDR_SPARE    = 2'd3
    } reg_addr_e;

    // Bit positions inside the control/status register
    localparam int CTL_FLAG_BIT = 3;
    localparam int CTL_ACK_BIT  = 2;
    localparam int CTL_IE_BIT   = 1;
    localparam int CTL_MODE_BIT = 0;
endpackage

// File: rtl/kbd_pin_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pins.
// Assumes each pin is independent; no cross-bit coherency is provided.
module kbd_pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the raw pins into the first stage
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= async_i;
            end
        end else begin : g_next
            // Shift the sample one stage further
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/kbd_trig_detect.sv
// Per-pin edge/level trigger generator.
// Compares the synchronised value with its previous sample. Assumes
// sync_i is already synchronous to clk.
module kbd_trig_detect #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_i,
    input  logic [WIDTH-1:0] en_i,
    input  logic [WIDTH-1:0] pol_i,
    input  logic             level_mode_i,
    output logic             trig_o
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] hit;

    // Remember last cycle's synchronised pin values
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_i;
    end

    genvar p;
    for (p = 0; p < WIDTH; p++) begin : g_pin
        logic rise, fall, edge_hit, level_hit;
        assign rise      = sync_i[p] & ~prev_q[p];
        assign fall      = ~sync_i[p] & prev_q[p];
        assign edge_hit  = pol_i[p] ? rise : fall;
        assign level_hit = (sync_i[p] == pol_i[p]);
        assign hit[p]    = en_i[p] & (edge_hit | (level_mode_i & level_hit));
    end

    assign trig_o = |hit;
endmodule

// File: rtl/kbd_regs.sv
// Register file and pending flag for the pin interrupt controller.
// The flag is set by trig_i and cleared by a write-one acknowledge.
// A trigger wins over an acknowledge in the same cycle. Assumes reads
// and writes are single-cycle strobes.
module kbd_regs
    import kbd_irq_pkg::*;
#(
    parameter int WIDTH = REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic              trig_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic [WIDTH-1:0]  en_o,
    output logic [WIDTH-1:0]  pol_o,
    output logic              ie_o,
    output logic              mode_o,
    output logic              flag_o
);
    logic      ie_q, mode_q, flag_q;
    logic [WIDTH-1:0] en_q, pol_q;
    reg_addr_e sel;
    logic      ack_wr;
    logic [REG_W-1:0] ctrl_view;

    assign sel    = reg_addr_e'(addr_i);
    assign ack_wr = wr_en_i && (sel == ADDR_CTRL) && wdata_i[CTL_ACK_BIT];

    // Configuration register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            mode_q <= 1'b0;
            en_q   <= '0;
            pol_q  <= '0;
        end else if (wr_en_i) begin
            case (sel)
                ADDR_CTRL: begin
                    ie_q   <= wdata_i[CTL_IE_BIT];
                    mode_q <= wdata_i[CTL_MODE_BIT];
                end
                ADDR_ENABLE:   en_q  <= wdata_i[WIDTH-1:0];
                ADDR_POLARITY: pol_q <= wdata_i[WIDTH-1:0];
                default: ;
            endcase
        end
    end

    // Sticky pending flag: trigger sets, acknowledge clears, trigger wins
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (trig_i) flag_q <= 1'b1;
        else if (ack_wr) flag_q <= 1'b0;
    end

    // Assemble the control/status read view
    always_comb begin
        ctrl_view               = '0;
        ctrl_view[CTL_FLAG_BIT] = flag_q;
        ctrl_view[CTL_IE_BIT]   = ie_q;
        ctrl_view[CTL_MODE_BIT] = mode_q;
    end

    // Read multiplexer, zero when idle or unmapped
    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            case (sel)
                ADDR_CTRL:     rdata_o = ctrl_view;
                ADDR_ENABLE:   rdata_o = REG_W'(en_q);
                ADDR_POLARITY: rdata_o = REG_W'(pol_q);
                default:       rdata_o = '0;
            endcase
        end
    end

    assign en_o   = en_q;
    assign pol_o  = pol_q;
    assign ie_o   = ie_q;
    assign mode_o = mode_q;
    assign flag_o = flag_q;
endmodule

// File: rtl/kbd_irq_ctrl.sv
// Top level of the keyboard pin interrupt controller.
// Chains synchroniser, trigger detector and register file. irq_o is the
// pending flag gated by the interrupt enable. Assumes pins_i is
// asynchronous and the register port is synchronous to clk.
module kbd_irq_ctrl
    import kbd_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  pins_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              irq_o
);
    localparam int PINS = REG_W;

    logic [PINS-1:0] pins_sync;
    logic [PINS-1:0] en_w, pol_w;
    logic            ie_w, mode_w, flag_w, trig_w;

    kbd_pin_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_i),
        .sync_o  (pins_sync)
    );

    kbd_trig_detect #(.WIDTH(PINS)) u_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_i       (pins_sync),
        .en_i         (en_w),
        .pol_i        (pol_w),
        .level_mode_i (mode_w),
        .trig_o       (trig_w)
    );

    kbd_regs #(.WIDTH(PINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (addr_i),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .wdata_i (wdata_i),
        .trig_i  (trig_w),
        .rdata_o (rdata_o),
        .en_o    (en_w),
        .pol_o   (pol_w),
        .ie_o    (ie_w),
        .mode_o  (mode_w),
        .flag_o  (flag_w)
    );

    assign irq_o = flag_w & ie_w;
endmodule

// File: rtl/kbd_irq_ctrl_checker.sv
// Protocol and flag-behaviour properties for kbd_irq_ctrl, bound to the top.
// Assumes strobes are sampled on the rising clock edge.
module kbd_irq_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] addr_i,
    input logic       wr_en_i,
    input logic       rd_en_i,
    input logic       ack_bit,
    input logic [7:0] rdata_o,
    input logic       irq_o,
    input logic       flag_q,
    input logic       trig
);
    // R2: reserved and acknowledge bits of the control view read zero
    a_r2_ctrl_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == 2'd0) |-> (rdata_o[7:4] == 4'd0 && rdata_o[2] == 1'b0));

    // R3: the flag can only rise after a detected event
    a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !trig) |=> !flag_q);

    // R4: acknowledge without a concurrent event clears the flag
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == 2'd0 && ack_bit && !trig) |=> !flag_q);

    // R5: an active request implies flag and enable both visible in a read
    a_r5_irq_matches_view: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == 2'd0 && irq_o) |-> (rdata_o[3] && rdata_o[1]));

    // R10: an event always leaves the flag set, even with an acknowledge
    a_r10_trigger_wins: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> flag_q);

    // R11: unmapped address and idle port read zero
    a_r11_quiet_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en_i || addr_i == 2'd3) |-> (rdata_o == 8'd0));
endmodule

bind kbd_irq_ctrl kbd_irq_ctrl_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .ack_bit (wdata_i[2]),
    .rdata_o (rdata_o),
    .irq_o   (irq_o),
    .flag_q  (flag_w),
    .trig    (trig_w)
);

// File: tb/kbd_irq_ctrl_bench.sv
// Self-checking bench: directed scenarios plus a behavioural per-cycle model.
module kbd_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pins = 8'hFF;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    kbd_irq_ctrl u_kbd_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .addr_i(addr),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] hist[$];
    logic [7:0] m_en, m_pol;
    logic       m_ie, m_mode, m_flag;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{8'd0, 8'd0, 8'd0};
            m_en = 0; m_pol = 0; m_ie = 0; m_mode = 0; m_flag = 0;
        end else begin
            bit event_seen;
            logic [7:0] cur, old;
            event_seen = 0;
            cur = hist[1];
            old = hist[0];
            for (int i = 0; i < 8; i++) begin
                if (m_en[i]) begin
                    bit went_up, went_down, at_level;
                    went_up   = cur[i] && !old[i];
                    went_down = !cur[i] && old[i];
                    at_level  = (cur[i] == m_pol[i]);
                    if ((m_pol[i] ? went_up : went_down) || (m_mode && at_level))
                        event_seen = 1;
                end
            end
            if (event_seen) m_flag = 1;
            else if (wr_en && addr == 2'd0 && wdata[2]) m_flag = 0;
            if (wr_en) begin
                case (addr)
                    2'd0: begin m_ie = wdata[1]; m_mode = wdata[0]; end
                    2'd1: m_en = wdata;
                    2'd2: m_pol = wdata;
                    default: ;
                endcase
            end
            hist.push_back(pins);
            void'(hist.pop_front());
        end
    end

    // Per-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        #3;
        if (rst_n && !done) begin
            checks++;
            if (irq !== (m_flag && m_ie)) begin
                errors++;
                $display("FAIL R5 model irq actual=%0b expected=%0b t=%0t", irq, m_flag && m_ie, $time);
            end
            if (!rd_en) begin
                checks++;
                if (rdata !== 8'd0) begin
                    errors++;
                    $display("FAIL R11 idle rdata actual=%h expected=00", rdata);
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = 8'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        #1 rd_en = 1'b0;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pins = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

    // ---------------- directed scenarios ----------------
    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl after reset", v, 8'h00);
        rd(2'd1, v); chk("R1 enable after reset", v, 8'h00);
        rd(2'd2, v); chk("R1 polarity after reset", v, 8'h00);
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);
        rd(2'd3, v); chk("R11 spare address", v, 8'h00);

        // Configure: pins 0..3 enabled, falling polarity, ie=1, mode=0
        wr(2'd1, 8'h0F);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'hFE);          // bits 7:3 and ack written; R2/R3
        rd(2'd1, v); chk("R11 enable readback", v, 8'h0F);
        rd(2'd0, v); chk("R2 R3 ctrl readback", v, 8'h02);
        idle(4);

        // R12 latency and R7 falling edge on pin0
        set_pins(8'hFE);
        @(negedge clk); @(negedge clk); #1;
        chk("R12 no irq after k+1", {7'd0, irq}, 8'h00);
        @(negedge clk); #1;
        chk("R12 R7 irq after k+2", {7'd0, irq}, 8'h01);
        rd(2'd0, v); chk("R5 ctrl flag and enable", v, 8'h0A);

        // R4 acknowledge, R6 held level does not re-trigger
        wr(2'd0, 8'h06);
        rd(2'd0, v); chk("R4 flag cleared", v, 8'h02);
        idle(4); #1;
        chk("R6 held low no retrigger", {7'd0, irq}, 8'h00);

        // R8 disabled pin 7 toggles
        set_pins(8'h7E); idle(4);
        set_pins(8'hFE); idle(4); #1;
        chk("R8 disabled pin ignored", {7'd0, irq}, 8'h00);

        // R7 wrong-direction edges ignored, right one taken
        set_pins(8'hFF); idle(4); #1;
        chk("R7 rising ignored on falling pin", {7'd0, irq}, 8'h00);
        wr(2'd2, 8'h02);
        set_pins(8'hFD); idle(4); #1;
        chk("R7 falling ignored on rising pin", {7'd0, irq}, 8'h00);
        set_pins(8'hFF); idle(4); #1;
        chk("R7 rising taken on rising pin", {7'd0, irq}, 8'h01);

        // R5 masking keeps flag
        wr(2'd0, 8'h00);
        rd(2'd0, v); chk("R5 masked flag kept", v, 8'h08);
        #1 chk("R5 irq masked", {7'd0, irq}, 8'h00);
        wr(2'd0, 8'h06);
        rd(2'd0, v); chk("R4 ack after mask", v, 8'h02);

        // R10 event coinciding with acknowledge
        set_pins(8'hFE); idle(4);
        set_pins(8'hFA);
        @(negedge clk);
        wr(2'd0, 8'h06);
        rd(2'd0, v); chk("R10 trigger beats ack", v, 8'h0A);
        wr(2'd0, 8'h06);
        rd(2'd0, v); chk("R4 ack clears", v, 8'h02);

        // R9 level mode with low levels still present
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h03);
        idle(3);
        wr(2'd0, 8'h07);
        rd(2'd0, v); chk("R9 ack ignored while level held", v, 8'h0B);
        set_pins(8'hFF); idle(4);
        wr(2'd0, 8'h07);
        rd(2'd0, v); chk("R9 ack works once level gone", v, 8'h03);
        idle(2); #1;
        chk("R9 irq low after release", {7'd0, irq}, 8'h00);

        // R7 high-level polarity in level mode on pin3
        wr(2'd2, 8'h08);
        idle(4);
        rd(2'd0, v); chk("R7 high level triggers", v, 8'h0B);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h07);
        rd(2'd0, v); chk("R4 final ack", v, 8'h03);
        rd(2'd2, v); chk("R11 polarity readback", v, 8'h00);

        idle(2);
        done = 1;
        summary();
    end
endmodule